// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a parameterised set of external interrupt sources and routes them to a parameterised set of hart contexts. Each source passes through its own gateway, which turns a level or a rising edge into a single pending request. Each source has a programmable priority, and each context has a per-source enable mask and a priority threshold. A context's interrupt line rises whenever one of its enabled sources is pending with a priority above its threshold.

Software handles an interrupt by reading the context's claim word. The read returns the best eligible source and retires its pending bit in the same cycle. It then writes that source number back to the same word to mark completion. Until completion, the source's gateway holds back new requests. For edge sources a build-time switch selects what happens to edges that arrive while the source is in flight: they are either counted in a small saturating counter and delivered again one by one, or discarded.

All state is reached through a word-addressed register port. Every cycle with `regValid` high is one access, and the answer comes back one cycle later.

Top module: `plic_core`

## Requirements
- R1: After reset, all priorities, enables, thresholds and pending bits are zero, every context line is low, and reads of those registers return 0.
- R2: Every cycle with regValid high is accepted. regReady is high in the next cycle, for exactly that cycle, with regRdata carrying the read result (0 for writes). regReady is low after a cycle without regValid.
- R3: The priority of source id (1..NUM_SRC) is at byte address 4*id and keeps only its low PRIO_W bits. Id 0 and ids above NUM_SRC read 0 and ignore writes.
- R4: A level source that is high and not in flight becomes pending. Pending bits are read at 0x1000 and up, with bit id of word id/32 for source id. Writes there have no effect.
- R5: The enable word w of context c is at 0x2000 + 0x80*c + 4*w, with bit id%32 for source id. Bit 0 and bits above NUM_SRC always read 0.
- R6: The threshold of context c is at 0x200000 + 0x1000*c. Line c is high exactly when some pending source enabled for c has a nonzero priority strictly greater than that threshold. An equal priority is masked.
- R7: A read of the claim word at 0x200004 + 0x1000*c returns the highest-priority pending source with a nonzero priority that is enabled for c, with the lowest id winning ties. The threshold does not affect this choice. The read clears that source's pending bit.
- R8: A claim read that finds no eligible source returns 0 and changes no pending state.
- R9: A claimed source raises no new request until a write of its id to the claim word. A level source that is still high becomes pending again after that write.
- R10: A completion write from a context that does not have the id enabled is ignored, and the source stays in flight.
- R11: An edge source becomes pending on a rising edge. With queuing selected, edges that arrive while it is in flight are counted, up to 2^QCNT_W-1, and each counted edge is delivered again after a completion.
- R12: With discarding selected, edges that arrive while an edge source is in flight are lost.
- R13: Any context that has a source enabled may claim it. Once claimed, that source no longer counts toward, and can no longer be claimed by, any other context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | NUM_SRC | Source inputs, bit i is source i+1 |
| regValid | input | 1 | Register access in this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address, word aligned |
| regWdata | input | 32 | Write data |
| regReady | output | 1 | Response valid, one cycle after the access |
| regRdata | output | 32 | Read data, valid with regReady |
| ctxIrq | output | NUM_CTX | Interrupt line of each context |

## Verification
A pending or in-flight bit that is wrong shows up on the context line right after the clock edge that corrupts it, and on the next pending-word or claim read. A broken arbiter returns the wrong id on the very next claim read. A queue counter that wraps or leaks either delivers extra claims after completion or loses them, and this is visible within one completion/claim round trip. Handshake faults show up as a missing or extra regReady in the cycle after the access.

// File: rtl/plic_pkg.sv
package plic_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_PEND,
    ACC_EN,
    ACC_THR,
    ACC_CLAIM
  } accKind_e;

  // One decoded register access, handed from control to datapath.
  typedef struct packed {
    logic        valid;
    logic        write;
    accKind_e    kind;
    logic [13:0] ctx;
    logic [9:0]  idx;
    logic [31:0] wdata;
  } regOp_t;

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter bit IS_EDGE     = 1'b0,
  parameter bit QUEUE_EDGES = 1'b1,
  parameter int QCNT_W      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcIn,
  input  logic claimHit,
  input  logic complHit,
  output logic pending
);

  logic              prevIn;
  logic              active;
  logic [QCNT_W-1:0] qCnt;
  logic              rise, idle, qNonZero, setPend, incr, decr;

  always_comb begin
    rise     = srcIn & ~prevIn;
    idle     = !pending && !active;
    qNonZero = (qCnt != '0);
    if (IS_EDGE) begin
      setPend = idle && (rise || qNonZero);
      incr    = QUEUE_EDGES && rise && (!idle || qNonZero);
      decr    = idle && qNonZero;
    end else begin
      setPend = idle && srcIn;
      incr    = 1'b0;
      decr    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= 1'b0;
      active  <= 1'b0;
      pending <= 1'b0;
      qCnt    <= '0;
    end else begin
      prevIn <= srcIn;
      if (claimHit) begin
        pending <= 1'b0;
        active  <= 1'b1;
      end else begin
        if (complHit) active <= 1'b0;
        if (setPend)  pending <= 1'b1;
      end
      if (incr && !decr && qCnt != {QCNT_W{1'b1}}) qCnt <= qCnt + 1'b1;
      else if (decr && !incr)                       qCnt <= qCnt - 1'b1;
    end
  end

  // R9: a source is never pending and in service at once
  p_one_flight_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(pending && active));

  // R7: a claim retires the pending request
  p_claim_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    claimHit |=> !pending);

  // R11: the queue counter saturates instead of wrapping
  p_queue_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    (qCnt == {QCNT_W{1'b1}} && rise && !idle) |=> qCnt == {QCNT_W{1'b1}});

endmodule

// File: rtl/plic_ctrl.sv
module plic_ctrl
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int NUM_CTX = 9,
  parameter int ADDR_W  = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic [31:0]       rdData,
  output regOp_t            op,
  output logic              regReady,
  output logic [31:0]       regRdata
);

  localparam int SRC_WORDS = (NUM_SRC + 32) / 32;

  logic [31:0] a, rel, sid, ctxNum, wordNum;

  always_comb begin
    op       = '0;
    op.valid = regValid;
    op.write = regWrite;
    op.wdata = regWdata;
    op.kind  = ACC_NONE;
    a        = 32'(regAddr);
    rel      = '0;
    sid      = '0;
    ctxNum   = '0;
    wordNum  = '0;
    if (a[1:0] == 2'b00) begin
      if (a < 32'h1000) begin
        sid = a >> 2;
        if (sid >= 1 && sid <= NUM_SRC) begin
          op.kind = ACC_PRIO;
          op.idx  = 10'(sid);
        end
      end else if (a < 32'h1080) begin
        wordNum = (a - 32'h1000) >> 2;
        if (wordNum < SRC_WORDS) begin
          op.kind = ACC_PEND;
          op.idx  = 10'(wordNum);
        end
      end else if (a >= 32'h2000 && a < 32'h200000) begin
        rel     = a - 32'h2000;
        ctxNum  = rel >> 7;
        wordNum = (rel & 32'h7F) >> 2;
        if (ctxNum < NUM_CTX && wordNum < SRC_WORDS) begin
          op.kind = ACC_EN;
          op.ctx  = 14'(ctxNum);
          op.idx  = 10'(wordNum);
        end
      end else if (a >= 32'h200000) begin
        rel    = a - 32'h200000;
        ctxNum = rel >> 12;
        if (ctxNum < NUM_CTX) begin
          op.ctx = 14'(ctxNum);
          if ((rel & 32'hFFF) == 32'h0) op.kind = ACC_THR;
          else if ((rel & 32'hFFF) == 32'h4) op.kind = ACC_CLAIM;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regReady <= 1'b0;
      regRdata <= '0;
    end else begin
      regReady <= regValid;
      regRdata <= (regValid && !regWrite) ? rdData : 32'h0;
    end
  end

  // R2: every access is answered in the following cycle
  p_ready_after_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    regValid |=> regReady);
  // R2: no answer without an access
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regValid |=> !regReady);

endmodule

// File: rtl/plic_datapath.sv
module plic_datapath
  import plic_pkg::*;
#(
  parameter int                 NUM_SRC     = 10,
  parameter int                 NUM_CTX     = 9,
  parameter int                 PRIO_W      = 3,
  parameter bit                 QUEUE_EDGES = 1'b1,
  parameter int                 QCNT_W      = 2,
  parameter logic [NUM_SRC-1:0] EDGE_SRC    = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  regOp_t             op,
  output logic [31:0]        rdData,
  output logic [NUM_CTX-1:0] ctxIrq
);

  localparam int ID_W      = $clog2(NUM_SRC + 1);
  localparam int SRC_WORDS = (NUM_SRC + 32) / 32;
  localparam int SRC_BITS  = SRC_WORDS * 32;
  localparam int WORD_W    = (SRC_WORDS > 1) ? $clog2(SRC_WORDS) : 1;
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam logic [SRC_BITS-1:0] SRC_MASK =
    ((SRC_BITS'(1) << (NUM_SRC + 1)) - SRC_BITS'(1)) & ~SRC_BITS'(1);

  logic [PRIO_W-1:0]   prio   [NUM_SRC+1];
  logic [SRC_BITS-1:0] enMask [NUM_CTX];
  logic [PRIO_W-1:0]   thr    [NUM_CTX];
  logic [ID_W-1:0]     bestId [NUM_CTX];
  logic [PRIO_W-1:0]   bestPr [NUM_CTX];

  logic [NUM_SRC:0]    pendVec;
  logic [SRC_BITS-1:0] pendPad;
  logic [NUM_SRC:1]    claimVec, complVec;

  logic [CTX_W-1:0]  cIdx;
  logic [ID_W-1:0]   sIdx, wId;
  logic [WORD_W-1:0] wIdx;

  assign cIdx    = CTX_W'(op.ctx);
  assign sIdx    = ID_W'(op.idx);
  assign wIdx    = WORD_W'(op.idx);
  assign wId     = ID_W'(op.wdata);
  assign pendVec[0] = 1'b0;
  assign pendPad = SRC_BITS'(pendVec);

  // Source gateways
  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gw
    plic_gateway #(
      .IS_EDGE    (EDGE_SRC[s-1]),
      .QUEUE_EDGES(QUEUE_EDGES),
      .QCNT_W     (QCNT_W)
    ) i_gw (
      .clk     (clk),
      .rstN    (rstN),
      .srcIn   (srcIrq[s-1]),
      .claimHit(claimVec[s]),
      .complHit(complVec[s]),
      .pending (pendVec[s])
    );
  end

  // Register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s <= NUM_SRC; s++) prio[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        enMask[c] <= '0;
        thr[c]    <= '0;
      end
    end else if (op.valid && op.write) begin
      case (op.kind)
        ACC_PRIO: prio[sIdx] <= op.wdata[PRIO_W-1:0];
        ACC_EN:   enMask[cIdx][wIdx*32 +: 32] <= op.wdata & SRC_MASK[wIdx*32 +: 32];
        ACC_THR:  thr[cIdx] <= op.wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // Per-context arbitration
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    always_comb begin
      bestId[c] = '0;
      bestPr[c] = '0;
      for (int s = NUM_SRC; s >= 1; s--) begin
        if (pendVec[s] && enMask[c][s] && prio[s] != '0 && prio[s] >= bestPr[c]) begin
          bestPr[c] = prio[s];
          bestId[c] = ID_W'(s);
        end
      end
      ctxIrq[c] = bestPr[c] > thr[c];
    end

    // R6: a raised line always has a pending, enabled source behind it
    p_irq_has_source_r6: assert property (@(posedge clk) disable iff (!rstN)
      ctxIrq[c] |-> |(pendPad & enMask[c]));
  end

  // Claim and completion strobes
  always_comb begin
    claimVec = '0;
    complVec = '0;
    if (op.valid && op.kind == ACC_CLAIM) begin
      if (!op.write) begin
        if (bestId[cIdx] != '0) claimVec[bestId[cIdx]] = 1'b1;
      end else if (op.wdata >= 1 && op.wdata <= NUM_SRC && enMask[cIdx][wId]) begin
        complVec[wId] = 1'b1;
      end
    end
  end

  // Read data
  always_comb begin
    rdData = '0;
    if (op.valid && !op.write) begin
      case (op.kind)
        ACC_PRIO:  rdData = 32'(prio[sIdx]);
        ACC_PEND:  rdData = pendPad[wIdx*32 +: 32];
        ACC_EN:    rdData = enMask[cIdx][wIdx*32 +: 32];
        ACC_THR:   rdData = 32'(thr[cIdx]);
        ACC_CLAIM: rdData = 32'(bestId[cIdx]);
        default:   rdData = '0;
      endcase
    end
  end

  // R7: at most one source is handed out per claim
  p_claim_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(claimVec));

  // R8: a claim that hands out nothing leaves the gateways untouched
  p_empty_claim_r8: assert property (@(posedge clk) disable iff (!rstN)
    (claimVec == '0) |-> !(op.valid && !op.write && op.kind == ACC_CLAIM && bestId[cIdx] != '0));

endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int                 NUM_SRC     = 10,
  parameter int                 NUM_CTX     = 9,
  parameter int                 PRIO_W      = 3,
  parameter int                 ADDR_W      = 26,
  parameter bit                 QUEUE_EDGES = 1'b1,
  parameter int                 QCNT_W      = 2,
  parameter logic [NUM_SRC-1:0] EDGE_SRC    = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic               regReady,
  output logic [31:0]        regRdata,
  output logic [NUM_CTX-1:0] ctxIrq
);

  regOp_t      op;
  logic [31:0] rdData;

  plic_ctrl #(
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX),
    .ADDR_W (ADDR_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .rdData  (rdData),
    .op      (op),
    .regReady(regReady),
    .regRdata(regRdata)
  );

  plic_datapath #(
    .NUM_SRC    (NUM_SRC),
    .NUM_CTX    (NUM_CTX),
    .PRIO_W     (PRIO_W),
    .QUEUE_EDGES(QUEUE_EDGES),
    .QCNT_W     (QCNT_W),
    .EDGE_SRC   (EDGE_SRC)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .srcIrq(srcIrq),
    .op    (op),
    .rdData(rdData),
    .ctxIrq(ctxIrq)
  );

endmodule

// File: tb/test_plic_core.sv
`timescale 1ns/1ps
module test_plic_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  srcIrq = '0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [25:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        readyA, readyB;
  logic [31:0] rdataA, rdataB;
  logic [8:0]  irqA, irqB;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  // Queuing instance
  plic_core #(.NUM_SRC(10), .NUM_CTX(9), .PRIO_W(3), .QUEUE_EDGES(1'b1),
              .QCNT_W(2), .EDGE_SRC(10'h300)) i_plic_core (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regReady(readyA), .regRdata(rdataA), .ctxIrq(irqA));

  // Discarding instance, same stimulus
  plic_core #(.NUM_SRC(10), .NUM_CTX(9), .PRIO_W(3), .QUEUE_EDGES(1'b0),
              .QCNT_W(2), .EDGE_SRC(10'h300)) i_plic_core_drop (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regReady(readyB), .regRdata(rdataB), .ctxIrq(irqB));

  function automatic logic [31:0] aPrio(int id); return 32'(4 * id); endfunction
  function automatic logic [31:0] aEn(int c);    return 32'h2000 + 32'(c * 32'h80); endfunction
  function automatic logic [31:0] aThr(int c);   return 32'h200000 + 32'(c * 32'h1000); endfunction
  function automatic logic [31:0] aClm(int c);   return aThr(c) + 32'h4; endfunction
  localparam logic [31:0] A_PEND = 32'h1000;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [31:0] data,
                      output logic [31:0] ra, output logic [31:0] rb);
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regAddr = addr[25:0]; regWdata = data;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    chkEq("R2", {30'h0, readyA, readyB}, 32'h3);
    ra = rdataA; rb = rdataB;
    @(negedge clk);
    chkEq("R2", {30'h0, readyA, readyB}, 32'h0);
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] data);
    logic [31:0] ra, rb;
    xfer(1'b1, addr, data, ra, rb);
    chkEq("R2", ra | rb, 32'h0);
  endtask

  task automatic rdA(input logic [31:0] addr, input string req, input logic [31:0] exp);
    logic [31:0] ra, rb;
    xfer(1'b0, addr, 32'h0, ra, rb);
    chkEq(req, ra, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    chkEq("R1", {23'h0, irqA}, 32'h0);
    rdA(aPrio(1), "R1", 0);
    rdA(aEn(0), "R1", 0);
    rdA(aThr(0), "R1", 0);
    rdA(A_PEND, "R1", 0);
    rdA(aClm(0), "R8", 0);
  endtask

  task automatic tRegMap();
    wr(aPrio(3), 5);         rdA(aPrio(3), "R3", 5);
    wr(aPrio(3), 32'hFF);    rdA(aPrio(3), "R3", 7);
    wr(aPrio(0), 7);         rdA(aPrio(0), "R3", 0);
    wr(aPrio(11), 7);        rdA(aPrio(11), "R3", 0);
    wr(aPrio(3), 0);
    wr(aEn(1), 32'hFFFF_FFFF); rdA(aEn(1), "R5", 32'h7FE);
    wr(aEn(1), 0);
    wr(aThr(4), 6);          rdA(aThr(4), "R6", 6);
    wr(aThr(4), 0);
  endtask

  task automatic tLevel();
    srcIrq[1] = 1'b1;          // source 2
    idle(2);
    rdA(A_PEND, "R4", 32'h4);
    wr(A_PEND, 0);
    rdA(A_PEND, "R4", 32'h4);
    wr(aPrio(2), 3);
    wr(aEn(0), 32'h4);
    chkEq("R6", {31'h0, irqA[0]}, 1);
    wr(aThr(0), 3);
    chkEq("R6", {31'h0, irqA[0]}, 0);
    wr(aThr(0), 2);
    chkEq("R6", {31'h0, irqA[0]}, 1);
    wr(aPrio(2), 0);
    chkEq("R6", {31'h0, irqA[0]}, 0);
    wr(aPrio(2), 3);
  endtask

  task automatic tArb();
    srcIrq[3] = 1'b1;          // source 4
    srcIrq[4] = 1'b1;          // source 5
    wr(aPrio(4), 5);
    wr(aPrio(5), 5);
    wr(aEn(0), 32'h34);
    wr(aThr(0), 7);
    chkEq("R6", {31'h0, irqA[0]}, 0);
    rdA(aClm(0), "R7", 4);
    rdA(A_PEND, "R9", 32'h24);
    rdA(aClm(0), "R7", 5);
    rdA(aClm(0), "R7", 2);
    rdA(aClm(0), "R8", 0);
    rdA(A_PEND, "R8", 0);
    wr(aClm(0), 4);
    idle(2);
    rdA(A_PEND, "R9", 32'h10);
    srcIrq[1] = 1'b0; srcIrq[3] = 1'b0; srcIrq[4] = 1'b0;
    wr(aClm(0), 2);
    wr(aClm(0), 5);
    idle(2);
    rdA(A_PEND, "R9", 32'h10);
    rdA(aClm(0), "R7", 4);
    wr(aClm(0), 4);
    idle(2);
    rdA(A_PEND, "R9", 0);
  endtask

  task automatic tOwner();
    wr(aThr(0), 0);
    wr(aPrio(3), 1);
    wr(aEn(0), 32'h8);
    srcIrq[2] = 1'b1;          // source 3
    idle(2);
    rdA(aClm(0), "R7", 3);
    wr(aClm(1), 3);
    idle(2);
    rdA(A_PEND, "R10", 0);
    wr(aClm(0), 3);
    idle(2);
    rdA(A_PEND, "R9", 32'h8);
    wr(aEn(1), 32'h8);
    chkEq("R13", {30'h0, irqA[1:0]}, 32'h3);
    rdA(aClm(1), "R13", 3);
    chkEq("R13", {30'h0, irqA[1:0]}, 32'h0);
    rdA(aClm(0), "R13", 0);
    srcIrq[2] = 1'b0;
    wr(aClm(1), 3);
    idle(2);
    rdA(A_PEND, "R9", 0);
    wr(aEn(0), 0);
    wr(aEn(1), 0);
  endtask

  task automatic pulse();
    @(negedge clk); srcIrq[8] = 1'b1;
    @(negedge clk); srcIrq[8] = 1'b0;
  endtask

  task automatic tEdge();
    logic [31:0] ra, rb;
    wr(aPrio(9), 2);
    wr(aEn(2), 32'h200);
    pulse();
    idle(1);
    xfer(1'b0, A_PEND, 0, ra, rb);
    chkEq("R11", ra, 32'h200);
    chkEq("R12", rb, 32'h200);
    xfer(1'b0, aClm(2), 0, ra, rb);
    chkEq("R11", ra, 9);
    chkEq("R12", rb, 9);
    for (int i = 0; i < 5; i++) pulse();
    idle(1);
    xfer(1'b0, A_PEND, 0, ra, rb);
    chkEq("R11", ra, 0);
    chkEq("R12", rb, 0);
    for (int k = 0; k < 4; k++) begin
      wr(aClm(2), 9);
      idle(2);
      xfer(1'b0, aClm(2), 0, ra, rb);
      chkEq("R11", ra, (k < 3) ? 32'd9 : 32'd0);
      chkEq("R12", rb, 0);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    tReset();
    tRegMap();
    tLevel();
    tArb();
    tOwner();
    tEdge();
    finishRun();
  end

endmodule